// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block behaves as the slave side of a three-wire serial EEPROM. A host selects it with `cs`, clocks serial bits on `sck` and presents them on `di`. The block waits for a start bit, takes in a two-bit opcode, an address and, for the two write commands, a data word. It then decodes one of seven instructions: read, word write, word erase, whole-array erase, whole-array write, program enable and program disable. Read data comes back on `do_o` with `do_oe` as the tri-state enable. `org` chooses between 16-bit words and 8-bit bytes over the same storage.

All serial inputs are assumed to be synchronous to the system clock `clk`, and `org` is held steady while a frame is in flight. A rising edge of `sck` is found by comparing it with its value one `clk` earlier. Programming time is modelled by a down-counter in `clk` cycles, one length per kind of operation. While that counter runs, the block drives its ready/busy status on `do_o` whenever `cs` is high. The array is a small register memory that a reset fills with all ones.

Top module: `mw_eeprom`

## Requirements
- R1: A frame starts at the first `sck` rise that sees `cs` and `di` both high while the block is idle. Until then, `sck` rises with `di` low leave `do_oe` low and start nothing.
- R2: The two bits after the start bit are the opcode, MSB first: 10 read, 01 write, 11 erase. Opcode 00 is split by the top two address bits: 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R3: With `org` high, words are 16 bits wide and the address has A16 bits. With `org` low, bytes are 8 bits wide and the address has A16+1 bits. Byte address b maps to bits [7:0] of word b>>1 when b is even and to bits [15:8] when b is odd.
- R4: On the `sck` rise that takes the last address bit of a read, `do_oe` goes high and `do_o` goes 0. Each of the next 16 rises (or 8 in byte mode) puts out one data bit, MSB first.
- R5: After reset the array holds all ones and programming is disabled. Write, erase, erase-all and write-all change nothing until an enable has run. A disable blocks them again. Reads work in either state.
- R6: Dropping `cs` before the last bit of a frame changes nothing. Once a frame is complete, further `sck` rises are ignored until `cs` goes low.
- R7: Erase sets the addressed word or byte to all ones, and erase-all does so for the whole array. Write-all stores the shifted-in word (or byte) at every location.
- R8: A programming command makes the block busy for T_WORD cycles (write, erase), T_ERAL cycles (erase-all) or T_WRAL cycles (write-all). While `cs` is high, `do_oe` is high and `do_o` is 0 when busy and 1 when ready. `do_oe` is low whenever `cs` is low outside a read.
- R9: A start bit that arrives while the block is busy is ignored, along with the rest of that frame.
- R10: A write stores the data bits it receives, MSB first, at the addressed word or byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock, sampled on `clk` |
| di | input | 1 | Serial data in |
| org | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| do_o | output | 1 | Serial data out: read data or ready/busy status |
| do_oe | output | 1 | Output enable for `do_o` |

## Verification
The bench builds the block with A16 = 4, which gives a 16-word array. Every location, including the last byte address in byte mode, is then reachable in short frames. Busy times are shortened to 200, 300 and 400 cycles. With those values the bench can measure each busy length, and it can push a whole second frame into the busy window to show that it is dropped.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_WRITE, CMD_ERASE,
    CMD_EWEN, CMD_EWDS, CMD_ERAL, CMD_WRAL
  } cmd_e;

  typedef enum logic [2:0] {
    FR_IDLE, FR_HDR, FR_DATA, FR_READ, FR_DONE
  } fr_state_e;
endpackage

// File: rtl/mw_busy.sv
module mw_busy #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] dur,
  output logic          busy
);
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)              cnt_n = dur;
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);

  // R8: busy window shrinks by exactly one per cycle
  a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int A16 = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         org,
  input  logic [A16:0] rd_addr,
  output logic [15:0]  rd_data,
  input  logic         we,
  input  logic         all,
  input  logic [A16:0] wr_addr,
  input  logic [15:0]  wr_data
);
  localparam int NB = 2 ** (A16 + 1);

  logic [7:0] mem [NB];

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam logic [A16:0] BI = (A16 + 1)'(i);
    logic hit;
    logic [7:0] val;
    always_comb begin
      hit = all || (org ? (wr_addr[A16-1:0] == BI[A16:1]) : (wr_addr == BI));
      val = (org && BI[0]) ? wr_data[15:8] : wr_data[7:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mem[i] <= 8'hFF;
      else if (we && hit)  mem[i] <= val;
    end
  end

  always_comb begin
    if (org) rd_data = {mem[{rd_addr[A16-1:0], 1'b1}], mem[{rd_addr[A16-1:0], 1'b0}]};
    else     rd_data = {8'h00, mem[rd_addr]};
  end
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int A16 = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         sck,
  input  logic         di,
  input  logic         org,
  input  logic         busy,
  output logic [A16:0] rd_addr,
  input  logic [15:0]  rd_word,
  output logic         exec,
  output cmd_e         cmd,
  output logic [A16:0] addr,
  output logic [15:0]  wdata,
  output logic         start,
  output logic         drive,
  output logic         do_bit
);
  localparam int HW = A16 + 3;
  localparam int CW = $clog2(HW + 17);

  fr_state_e         st_q, st_n;
  logic [CW-1:0]     bc_q, bc_n;
  logic [HW-2:0]     hdr_q, hdr_n;
  logic [15:0]       osr_q, osr_n, dsr_q, dsr_n;
  cmd_e              cmd_q, cmd_n, dec;
  logic [A16:0]      adr_q, adr_n;
  logic              sck_q, ex_q, ex_n, st1_q, st1_n, drv_q, drv_n, do_q, do_n;
  logic              rise, hlast, dlast;
  logic [HW-1:0]     full;
  logic [1:0]        op, sub;

  assign rise  = sck && !sck_q;
  assign full  = {hdr_q, di};
  assign op    = org ? full[A16+1:A16]   : full[A16+2:A16+1];
  assign sub   = org ? full[A16-1:A16-2] : full[A16:A16-1];
  assign rd_addr = org ? {1'b0, full[A16-1:0]} : full[A16:0];
  assign hlast = org ? (bc_q == CW'(A16 + 1)) : (bc_q == CW'(A16 + 2));
  assign dlast = org ? (bc_q == CW'(15)) : (bc_q == CW'(7));

  always_comb begin
    unique case (op)
      2'b10:   dec = CMD_READ;
      2'b01:   dec = CMD_WRITE;
      2'b11:   dec = CMD_ERASE;
      default: unique case (sub)
        2'b11:   dec = CMD_EWEN;
        2'b00:   dec = CMD_EWDS;
        2'b10:   dec = CMD_ERAL;
        default: dec = CMD_WRAL;
      endcase
    endcase
  end

  always_comb begin
    st_n = st_q;  bc_n = bc_q;  hdr_n = hdr_q;  osr_n = osr_q;  dsr_n = dsr_q;
    cmd_n = cmd_q;  adr_n = adr_q;  ex_n = 1'b0;  st1_n = 1'b0;
    drv_n = drv_q;  do_n = do_q;
    if (!cs) begin
      st_n = FR_IDLE;
      drv_n = 1'b0;
    end else if (rise) begin
      unique case (st_q)
        FR_IDLE: if (di && !busy) begin
          st_n = FR_HDR;  bc_n = '0;  hdr_n = '0;  st1_n = 1'b1;
        end
        FR_HDR: begin
          hdr_n = full[HW-2:0];
          bc_n  = bc_q + 1'b1;
          if (hlast) begin
            cmd_n = dec;  adr_n = rd_addr;  bc_n = '0;
            if (dec == CMD_READ) begin
              st_n = FR_READ;  drv_n = 1'b1;  do_n = 1'b0;
              osr_n = org ? rd_word : {rd_word[7:0], 8'h00};
            end else if (dec == CMD_WRITE || dec == CMD_WRAL) begin
              st_n = FR_DATA;
            end else begin
              st_n = FR_DONE;  ex_n = 1'b1;
            end
          end
        end
        FR_DATA: begin
          dsr_n = {dsr_q[14:0], di};
          bc_n  = bc_q + 1'b1;
          if (dlast) begin
            st_n = FR_DONE;  ex_n = 1'b1;
          end
        end
        FR_READ: begin
          do_n  = osr_q[15];
          osr_n = {osr_q[14:0], 1'b0};
          bc_n  = bc_q + 1'b1;
          if (dlast) st_n = FR_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FR_IDLE;  bc_q <= '0;  hdr_q <= '0;  osr_q <= '0;  dsr_q <= '0;
      cmd_q <= CMD_NONE;  adr_q <= '0;  sck_q <= 1'b0;  ex_q <= 1'b0;
      st1_q <= 1'b0;  drv_q <= 1'b0;  do_q <= 1'b0;
    end else begin
      st_q <= st_n;  bc_q <= bc_n;  hdr_q <= hdr_n;  osr_q <= osr_n;  dsr_q <= dsr_n;
      cmd_q <= cmd_n;  adr_q <= adr_n;  sck_q <= sck;  ex_q <= ex_n;
      st1_q <= st1_n;  drv_q <= drv_n;  do_q <= do_n;
    end
  end

  assign exec   = ex_q;
  assign cmd    = cmd_q;
  assign addr   = adr_q;
  assign wdata  = org ? dsr_q : {8'h00, dsr_q[7:0]};
  assign start  = st1_q;
  assign drive  = drv_q;
  assign do_bit = do_q;

  // R6: deselect always returns the framer to idle
  a_r6_deselect_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (st_q == FR_IDLE));
  // R6: a finished frame stays finished while selected
  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_DONE && cs) |=> (st_q == FR_DONE || $past(!cs) || !cs));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int A16    = 6,
  parameter int T_WORD = 500000,
  parameter int T_ERAL = 1500000,
  parameter int T_WRAL = 3000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic di,
  input  logic org,
  output logic do_o,
  output logic do_oe
);
  localparam int TM1 = (T_WORD > T_ERAL) ? T_WORD : T_ERAL;
  localparam int TMX = (TM1 > T_WRAL) ? TM1 : T_WRAL;
  localparam int CW  = $clog2(TMX + 1);

  logic [1:0]    rs_q;
  logic          rst_i, exec, start, drive, do_bit, busy, wen_q, stat_q, prog, all;
  cmd_e          cmd;
  logic [A16:0]  rd_addr, addr;
  logic [15:0]   rd_word, wdata, wr_data;
  logic [CW-1:0] dur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  mw_frame #(.A16(A16)) u_frame (
    .clk(clk), .rst_n(rst_i), .cs(cs), .sck(sck), .di(di), .org(org), .busy(busy),
    .rd_addr(rd_addr), .rd_word(rd_word), .exec(exec), .cmd(cmd), .addr(addr),
    .wdata(wdata), .start(start), .drive(drive), .do_bit(do_bit)
  );

  assign prog = exec && wen_q &&
                (cmd == CMD_WRITE || cmd == CMD_ERASE || cmd == CMD_ERAL || cmd == CMD_WRAL);
  assign all  = (cmd == CMD_ERAL) || (cmd == CMD_WRAL);
  assign wr_data = (cmd == CMD_ERASE || cmd == CMD_ERAL) ? 16'hFFFF : wdata;

  always_comb begin
    unique case (cmd)
      CMD_ERAL: dur = CW'(T_ERAL);
      CMD_WRAL: dur = CW'(T_WRAL);
      default:  dur = CW'(T_WORD);
    endcase
  end

  mw_store #(.A16(A16)) u_store (
    .clk(clk), .rst_n(rst_i), .org(org), .rd_addr(rd_addr), .rd_data(rd_word),
    .we(prog), .all(all), .wr_addr(addr), .wr_data(wr_data)
  );

  mw_busy #(.CW(CW)) u_busy (
    .clk(clk), .rst_n(rst_i), .load(prog), .dur(dur), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      wen_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (exec && cmd == CMD_EWEN)      wen_q <= 1'b1;
      else if (exec && cmd == CMD_EWDS) wen_q <= 1'b0;
      if (prog)       stat_q <= 1'b1;
      else if (start) stat_q <= 1'b0;
    end
  end

  assign do_oe = cs && (drive || stat_q);
  assign do_o  = drive ? do_bit : !busy;

  // R9: the framer never opens a frame during programming
  a_r9_no_start_busy: assert property (@(posedge clk) disable iff (!rst_i)
    start |-> !$past(busy));
  // R6: commands only complete on a selected clock edge
  a_r6_exec_selected: assert property (@(posedge clk) disable iff (!rst_i)
    exec |-> $past(cs));
  // R8: selected and busy outside a read shows busy low
  a_r8_status_busy: assert property (@(posedge clk) disable iff (!rst_i)
    (cs && busy && stat_q && !drive) |-> (do_oe && !do_o));
endmodule

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
  localparam int CLK_PERIOD = 10;
  localparam int A16 = 4;
  localparam int TW = 200, TE = 300, TA = 400;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, di = 1'b0, org = 1'b1;
  logic do_o, do_oe;
  int n_chk = 0, n_bad = 0;

  mw_eeprom #(.A16(A16), .T_WORD(TW), .T_ERAL(TE), .T_WRAL(TA)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di), .org(org),
    .do_o(do_o), .do_oe(do_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // kind: 0 enable 1 write 2 read 3 erase 4 disable 5 erase-all 6 write-all
  localparam logic [43:0] VEC [23] = '{
    {1'b1, 3'd2, 8'h03, 16'h0000, 16'hFFFF},
    {1'b1, 3'd1, 8'h03, 16'h1234, 16'h0000},
    {1'b1, 3'd2, 8'h03, 16'h0000, 16'hFFFF},
    {1'b1, 3'd0, 8'h00, 16'h0000, 16'h0000},
    {1'b1, 3'd1, 8'h03, 16'hA5C3, 16'h0000},
    {1'b1, 3'd2, 8'h03, 16'h0000, 16'hA5C3},
    {1'b0, 3'd2, 8'h06, 16'h0000, 16'h00C3},
    {1'b0, 3'd2, 8'h07, 16'h0000, 16'h00A5},
    {1'b0, 3'd1, 8'h07, 16'h005A, 16'h0000},
    {1'b1, 3'd2, 8'h03, 16'h0000, 16'h5AC3},
    {1'b1, 3'd3, 8'h03, 16'h0000, 16'h0000},
    {1'b1, 3'd2, 8'h03, 16'h0000, 16'hFFFF},
    {1'b1, 3'd1, 8'h00, 16'h0F0F, 16'h0000},
    {1'b1, 3'd2, 8'h00, 16'h0000, 16'h0F0F},
    {1'b1, 3'd6, 8'h00, 16'h1357, 16'h0000},
    {1'b1, 3'd2, 8'h00, 16'h0000, 16'h1357},
    {1'b1, 3'd2, 8'h0F, 16'h0000, 16'h1357},
    {1'b0, 3'd6, 8'h00, 16'h009C, 16'h0000},
    {1'b1, 3'd2, 8'h05, 16'h0000, 16'h9C9C},
    {1'b1, 3'd5, 8'h00, 16'h0000, 16'h0000},
    {1'b0, 3'd2, 8'h1F, 16'h0000, 16'h00FF},
    {1'b1, 3'd4, 8'h00, 16'h0000, 16'h0000},
    {1'b1, 3'd1, 8'h02, 16'hBEEF, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b, output logic ob, output logic oeb);
    @(negedge clk); di = b; sck = 1'b1;
    @(negedge clk);
    @(negedge clk); ob = do_o; oeb = do_oe; sck = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    logic ob, oeb;
    for (int i = n - 1; i >= 0; i--) pulse(v[i], ob, oeb);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    @(negedge clk); cs = 1'b1;
    @(negedge clk);
    while (do_oe && !do_o && n < 5000) begin
      @(negedge clk); n++;
    end
    cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input logic o, input logic [2:0] kind, input logic [7:0] adr,
                     input logic [15:0] data, output logic [15:0] rd, output logic dz);
    logic [1:0] op;
    logic [7:0] a;
    logic ob, oeb;
    int aw, dl, n;
    aw = o ? A16 : A16 + 1;
    dl = o ? 16 : 8;
    a = adr;
    case (kind)
      3'd0: begin op = 2'b00; a = 8'(3 << (aw - 2)); end
      3'd1: op = 2'b01;
      3'd2: op = 2'b10;
      3'd3: op = 2'b11;
      3'd4: begin op = 2'b00; a = 8'h00; end
      3'd5: begin op = 2'b00; a = 8'(2 << (aw - 2)); end
      default: begin op = 2'b00; a = 8'(1 << (aw - 2)); end
    endcase
    org = o;
    @(negedge clk); cs = 1'b1;
    pulse(1'b1, ob, oeb);
    pulse(op[1], ob, oeb);
    pulse(op[0], ob, oeb);
    for (int i = aw - 1; i >= 0; i--) pulse(a[i], ob, oeb);
    dz = oeb && !ob;
    if (kind == 3'd1 || kind == 3'd6)
      for (int i = dl - 1; i >= 0; i--) pulse(data[i], ob, oeb);
    rd = '0;
    if (kind == 3'd2)
      for (int i = 0; i < dl; i++) begin
        pulse(1'b0, ob, oeb);
        rd = {rd[14:0], ob};
      end
    @(negedge clk); cs = 1'b0;
    @(negedge clk);
    if (kind == 3'd1 || kind == 3'd3 || kind == 3'd5 || kind == 3'd6) wait_ready(n);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] rd;
    logic dz, ob, oeb;
    int n;
    repeat (3) @(negedge clk);
    chk("R8 reset hi-Z", {31'd0, do_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R2 R3 R4 R5 R7 R10
    for (int i = 0; i < 23; i++) begin
      run(VEC[i][43], VEC[i][42:40], VEC[i][39:32], VEC[i][31:16], rd, dz);
      if (VEC[i][42:40] == 3'd2) begin
        chk($sformatf("R2/R3/R5/R7/R10 read vec %0d", i), {16'd0, rd}, {16'd0, VEC[i][15:0]});
        chk($sformatf("R4 dummy zero vec %0d", i), {31'd0, dz}, 32'd1);
      end
    end
    run(1'b1, 3'd2, 8'h02, 16'h0, rd, dz);
    chk("R5 write ignored after disable", {16'd0, rd}, 32'h0000FFFF);

    // R1: zeros while selected start nothing
    org = 1'b1;
    @(negedge clk); cs = 1'b1;
    for (int i = 0; i < 4; i++) pulse(1'b0, ob, oeb);
    chk("R1 no start on zeros", {31'd0, oeb}, 32'd0);
    @(negedge clk); cs = 1'b0;
    @(negedge clk); sck = 1'b1; di = 1'b1;
    repeat (2) @(negedge clk); sck = 1'b0;
    @(negedge clk);
    chk("R1 no start while deselected", {31'd0, do_oe}, 32'd0);
    run(1'b1, 3'd4 - 3'd2, 8'h04, 16'h0, rd, dz);
    chk("R1 frame after idle activity", {16'd0, rd}, 32'h0000FFFF);

    // R6: aborted frame
    run(1'b1, 3'd0, 8'h00, 16'h0, rd, dz);
    @(negedge clk); cs = 1'b1;
    send_bits({1'b1, 2'b01, 4'h1, 8'h55}, 15);
    @(negedge clk); cs = 1'b0;
    repeat (2) @(negedge clk);
    run(1'b1, 3'd2, 8'h01, 16'h0, rd, dz);
    chk("R6 aborted write leaves word", {16'd0, rd}, 32'h0000FFFF);

    // R6: bits after a complete read are ignored until deselect
    @(negedge clk); cs = 1'b1;
    send_bits({1'b1, 2'b10, 4'h1}, 7);
    send_bits(32'h0, 16);
    send_bits({1'b1, 2'b01, 4'h1, 16'hAAAA}, 23);
    @(negedge clk); cs = 1'b0;
    repeat (TW + 20) @(negedge clk);
    run(1'b1, 3'd2, 8'h01, 16'h0, rd, dz);
    chk("R6 trailing frame ignored", {16'd0, rd}, 32'h0000FFFF);

    // R8: word busy time and status levels
    org = 1'b1;
    @(negedge clk); cs = 1'b1;
    send_bits({1'b1, 2'b01, 4'h2, 16'h1111}, 23);
    chk("R8 busy shown low", {30'd0, do_oe, do_o}, 32'd2);
    n = 0;
    while (!do_o && n < 5000) begin @(negedge clk); n++; end
    chk("R8 word busy length", {31'd0, (n >= TW - 10 && n <= TW)}, 32'd1);
    chk("R8 ready shown high", {30'd0, do_oe, do_o}, 32'd3);
    cs = 1'b0;
    @(negedge clk);
    chk("R8 hi-Z on deselect", {31'd0, do_oe}, 32'd0);
    run(1'b1, 3'd2, 8'h02, 16'h0, rd, dz);
    chk("R10 word written", {16'd0, rd}, 32'h00001111);

    // R9: frame during busy is dropped
    @(negedge clk); cs = 1'b1;
    send_bits({1'b1, 2'b01, 4'h3, 16'h2222}, 23);
    send_bits({1'b1, 2'b01, 4'h4, 16'h3333}, 23);
    @(negedge clk); cs = 1'b0;
    wait_ready(n);
    run(1'b1, 3'd2, 8'h04, 16'h0, rd, dz);
    chk("R9 busy frame dropped", {16'd0, rd}, 32'h0000FFFF);
    run(1'b1, 3'd2, 8'h03, 16'h0, rd, dz);
    chk("R10 first frame kept", {16'd0, rd}, 32'h00002222);

    // R8: erase-all and write-all durations
    @(negedge clk); cs = 1'b1;
    send_bits({1'b1, 2'b00, 4'b1000}, 7);
    n = 0;
    while (!do_o && n < 5000) begin @(negedge clk); n++; end
    chk("R8 erase-all busy length", {31'd0, (n >= TE - 10 && n <= TE)}, 32'd1);
    cs = 1'b0;
    @(negedge clk); cs = 1'b1;
    send_bits({1'b1, 2'b00, 4'b0100, 16'h7E81}, 23);
    n = 0;
    while (!do_o && n < 5000) begin @(negedge clk); n++; end
    chk("R8 write-all busy length", {31'd0, (n >= TA - 10 && n <= TA)}, 32'd1);
    cs = 1'b0;
    @(negedge clk);
    run(1'b0, 3'd2, 8'h1D, 16'h0, rd, dz);
    chk("R7 write-all odd byte", {16'd0, rd}, 32'h0000007E);
    run(1'b0, 3'd3, 8'h1D, 16'h0, rd, dz);
    run(1'b1, 3'd2, 8'h0E, 16'h0, rd, dz);
    chk("R7 byte erase", {16'd0, rd}, 32'h0000FF81);

    // R5: reset restores ones and the disabled state
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run(1'b1, 3'd2, 8'h0E, 16'h0, rd, dz);
    chk("R5 reset fills ones", {16'd0, rd}, 32'h0000FFFF);
    run(1'b1, 3'd1, 8'h0E, 16'h4321, rd, dz);
    run(1'b1, 3'd2, 8'h0E, 16'h0, rd, dz);
    chk("R5 reset disables writes", {16'd0, rd}, 32'h0000FFFF);

    summary();
  end
endmodule